// File: doc/BRIEF.md
# Steerable Watchdog Timer

This block is a watchdog timer set up through one byte-wide control register. The low two bits choose a resolution of 1, 4, 16 or 64. The five bits above them give a multiplier. Together they set a timeout counted in ticks of an external 16 Hz strobe, which makes the unit one sixteenth of a second. The top bit is a steering bit. It decides what the block does when the count runs out: ask for a system reset, or raise a one-cycle interrupt. In both cases a sticky expiry flag is set.

Software services the watchdog by writing the control register or by reading it. Either access reloads the countdown. A write also loads a new setting and clears the flag. A setting whose multiplier is zero leaves the watchdog disabled. A century bit is also kept here, because an expiry steered to reset must clear it. Producing the 16 Hz tick is the job of the surrounding logic.

The control is a three-state machine:
- `ST_IDLE`: disarmed, not counting.
- `ST_RUN`: counting ticks down.
- `ST_FIRE`: the expiry cycle, which drives the selected pulse.

Its transitions:
- `T_ARM`: a restart with a nonzero multiplier, from any state, enters `ST_RUN`.
- `T_DISARM`: a restart with a zero multiplier enters `ST_IDLE`.
- `T_COUNT`: a tick that is not the final one keeps `ST_RUN`.
- `T_EXPIRE`: the final tick moves `ST_RUN` to `ST_FIRE`.
- `T_SETTLE`: `ST_FIRE` falls back to `ST_IDLE` when no restart is present.

Top module: `wdog_steer`

## Requirements
- R1: After a restart, the expiry pulse appears in the clock cycle right after the N-th accepted tick, and not before. N = multiplier × 4^resolution. The multiplier is bits 6:2 and the resolution is bits 1:0 of the control value.
- R2: A control value whose multiplier field (bits 6:2) is zero, including the value 0x00, never produces a reset or interrupt pulse, however many ticks arrive.
- R3: A write strobe stores the byte, which appears on `reg_rdata` from the next cycle. It also clears the expiry flag and restarts the countdown from the new value.
- R4: A read strobe restarts the countdown from the stored value. It changes neither the stored value nor the flag.
- R5: Every expiry sets `flag_o` from the cycle after the pulse. The flag stays set, reads included, until the next write.
- R6: With bit 7 set, an expiry gives a one-cycle `rst_req_o` pulse. From the next cycle the stored control value is 0x00 and `century_o` is 0.
- R7: With bit 7 clear, an expiry gives exactly one one-cycle `irq_o` pulse. The stored value and `century_o` are kept. No further pulse comes until the next restart.
- R8: `rst_req_o` and `irq_o` are never high together.
- R9: After reset the stored value is 0x00, the flag and the century bit are 0, and both pulse outputs are low.
- R10: `cent_ld` loads `cent_val` into the century bit. If it coincides with a reset-steered expiry, the load wins.
- R11: A tick that arrives in the same cycle as a write or read strobe is not counted. Ticks in `ST_IDLE` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control byte to write |
| reg_rd | input | 1 | Control register read strobe (restarts timer) |
| reg_rdata | output | 8 | Stored control byte |
| tick_i | input | 1 | One-cycle strobe at 16 Hz |
| cent_ld | input | 1 | Century bit load strobe |
| cent_val | input | 1 | Century bit value to load |
| rst_req_o | output | 1 | One-cycle system reset request |
| irq_o | output | 1 | One-cycle interrupt pulse |
| flag_o | output | 1 | Sticky watchdog expiry flag |
| century_o | output | 1 | Century bit |

## Verification
The assertions assume that a write or read strobe comes as a single-cycle pulse driven between clock edges. They also assume that nothing outside the block changes the stored value except a write, so the cycle before any pulse must hold a nonzero multiplier. The stimulus keeps to this by driving every strobe and tick for one cycle after a falling edge. Random trials draw settings with a forced nonzero multiplier and random steering, and separate gaps between ticks by zero to two idle cycles. Directed cases then cover the disabled settings, restarts that coincide with a tick, and a century load in the expiry cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIRE = 2'd2
    } wd_state_e;

    // Counter width needed for multiplier << (2 * max resolution code)
    function automatic int cnt_width(input int mult_w, input int res_w);
        return mult_w + 2 * ((1 << res_w) - 1);
    endfunction

endpackage

// File: rtl/wdog_cfg.sv
module wdog_cfg #(
    parameter int MULT_W = 5,
    parameter int RES_W  = 2,
    parameter int CFG_W  = 1 + MULT_W + RES_W,
    parameter int CNT_W  = wdog_pkg::cnt_width(MULT_W, RES_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CFG_W-1:0] wdata,
    input  logic             bite_rst,
    input  logic             bite_any,
    input  logic             cent_ld,
    input  logic             cent_val,
    output logic [CFG_W-1:0] cfg_q,
    output logic [CNT_W-1:0] timeout,
    output logic             arm_ok,
    output logic             steer,
    output logic             flag_q,
    output logic             century_q
);
    localparam int NRES = 1 << RES_W;

    logic [CFG_W-1:0]  src;
    logic [MULT_W-1:0] mult;
    logic [RES_W-1:0]  res;
    logic [CNT_W-1:0]  scaled [NRES];

    // A write restarts from the byte being written, a read from the stored one
    assign src  = wr ? wdata : cfg_q;
    assign mult = src[RES_W +: MULT_W];
    assign res  = src[RES_W-1:0];

    for (genvar g = 0; g < NRES; g++) begin : g_scale
        assign scaled[g] = {{(CNT_W-MULT_W){1'b0}}, mult} << (2 * g);
    end

    assign timeout = scaled[res];
    assign arm_ok  = (mult != '0);
    assign steer   = cfg_q[CFG_W-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            flag_q    <= 1'b0;
            century_q <= 1'b0;
        end else begin
            if (wr)
                cfg_q <= wdata;
            else if (bite_rst)
                cfg_q <= '0;

            if (wr)
                flag_q <= 1'b0;
            else if (bite_any)
                flag_q <= 1'b1;

            if (cent_ld)
                century_q <= cent_val;
            else if (bite_rst)
                century_q <= 1'b0;
        end
    end
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (dec && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == {{(CNT_W-1){1'b0}}, 1'b1});
endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import wdog_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic arm_ok,
    input  logic tick,
    input  logic last,
    input  logic steer,
    output logic load,
    output logic dec,
    output logic fire_rst,
    output logic fire_irq
);
    wd_state_e state_q, state_d;

    // Next-state logic: T_ARM, T_DISARM, T_COUNT, T_EXPIRE, T_SETTLE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (restart && arm_ok)
                    state_d = ST_RUN;                  // T_ARM
            end
            ST_RUN: begin
                if (restart)
                    state_d = arm_ok ? ST_RUN : ST_IDLE; // T_ARM / T_DISARM
                else if (tick && last)
                    state_d = ST_FIRE;                 // T_EXPIRE
            end
            ST_FIRE: begin
                if (restart && arm_ok)
                    state_d = ST_RUN;                  // T_ARM
                else
                    state_d = ST_IDLE;                 // T_SETTLE / T_DISARM
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Output logic
    always_comb begin
        load     = restart;
        dec      = 1'b0;
        fire_rst = 1'b0;
        fire_irq = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RUN:  dec = tick && !restart;
            ST_FIRE: begin
                fire_rst = steer;
                fire_irq = !steer;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/wdog_steer.sv
module wdog_steer #(
    parameter int MULT_W = 5,
    parameter int RES_W  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_wr,
    input  logic [MULT_W+RES_W:0]     reg_wdata,
    input  logic                      reg_rd,
    output logic [MULT_W+RES_W:0]     reg_rdata,
    input  logic                      tick_i,
    input  logic                      cent_ld,
    input  logic                      cent_val,
    output logic                      rst_req_o,
    output logic                      irq_o,
    output logic                      flag_o,
    output logic                      century_o
);
    localparam int CFG_W = 1 + MULT_W + RES_W;
    localparam int CNT_W = wdog_pkg::cnt_width(MULT_W, RES_W);

    logic [CNT_W-1:0] timeout;
    logic             arm_ok, steer, last, load, dec, fire_rst, fire_irq;
    logic             restart;

    assign restart = reg_wr | reg_rd;

    wdog_cfg #(
        .MULT_W(MULT_W), .RES_W(RES_W), .CFG_W(CFG_W), .CNT_W(CNT_W)
    ) cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (reg_wr),
        .wdata     (reg_wdata),
        .bite_rst  (fire_rst),
        .bite_any  (fire_rst | fire_irq),
        .cent_ld   (cent_ld),
        .cent_val  (cent_val),
        .cfg_q     (reg_rdata),
        .timeout   (timeout),
        .arm_ok    (arm_ok),
        .steer     (steer),
        .flag_q    (flag_o),
        .century_q (century_o)
    );

    wdog_count #(.CNT_W(CNT_W)) cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (timeout),
        .dec      (dec),
        .last     (last)
    );

    wdog_fsm fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .arm_ok   (arm_ok),
        .tick     (tick_i),
        .last     (last),
        .steer    (steer),
        .load     (load),
        .dec      (dec),
        .fire_rst (fire_rst),
        .fire_irq (fire_irq)
    );

    assign rst_req_o = fire_rst;
    assign irq_o     = fire_irq;
endmodule

// File: rtl/wdog_steer_chk.sv
module wdog_steer_chk #(
    parameter int MULT_W = 5,
    parameter int RES_W  = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  reg_wr,
    input logic [MULT_W+RES_W:0] reg_rdata,
    input logic                  cent_ld,
    input logic                  rst_req_o,
    input logic                  irq_o,
    input logic                  flag_o,
    input logic                  century_o
);
    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rst_req_o && irq_o)); // R8

    AST_RST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> !rst_req_o); // R6

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o); // R7

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req_o || irq_o) && !reg_wr |=> flag_o); // R5

    AST_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !flag_o); // R3

    AST_RST_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o && !reg_wr && !cent_ld |=> (reg_rdata == '0) && !century_o); // R6

    AST_IRQ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o && !reg_wr |=> $stable(reg_rdata)); // R7

    AST_ARMED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req_o || irq_o) |-> $past(reg_rdata[RES_W +: MULT_W]) != '0); // R2
endmodule

bind wdog_steer wdog_steer_chk #(.MULT_W(MULT_W), .RES_W(RES_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rdata (reg_rdata),
    .cent_ld   (cent_ld),
    .rst_req_o (rst_req_o),
    .irq_o     (irq_o),
    .flag_o    (flag_o),
    .century_o (century_o)
);

// File: tb/wdog_steer_tb_top.sv
module wdog_steer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0, tick_i = 1'b0;
    logic       cent_ld = 1'b0, cent_val = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       rst_req_o, irq_o, flag_o, century_o;

    int checks = 0;
    int errors = 0;
    int n_rst = 0;
    int n_irq = 0;

    always #5 clk = ~clk;

    wdog_steer dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rd(reg_rd), .reg_rdata(reg_rdata), .tick_i(tick_i),
        .cent_ld(cent_ld), .cent_val(cent_val), .rst_req_o(rst_req_o),
        .irq_o(irq_o), .flag_o(flag_o), .century_o(century_o)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            n_rst = n_rst + int'(rst_req_o);
            n_irq = n_irq + int'(irq_o);
        end
    end

    function automatic int exp_ticks(input logic [7:0] v);
        return int'(v[6:2]) << (2 * int'(v[1:0]));
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] v, input logic t);
        reg_wr = 1'b1; reg_wdata = v; tick_i = t;
        cyc();
        reg_wr = 1'b0; tick_i = 1'b0;
    endtask

    task automatic rd(input logic t);
        reg_rd = 1'b1; tick_i = t;
        cyc();
        reg_rd = 1'b0; tick_i = 1'b0;
    endtask

    task automatic tick1();
        tick_i = 1'b1;
        cyc();
        tick_i = 1'b0;
    endtask

    task automatic ticks(input int n, input bit rand_gap);
        for (int i = 0; i < n; i++) begin
            if (rand_gap) repeat ($urandom_range(0, 2)) cyc();
            tick1();
        end
    endtask

    // Full expiry run of one setting with checks of the outcome
    task automatic run_trial(input logic [7:0] v);
        int t, r0, i0;
        bit st;
        t  = exp_ticks(v);
        st = v[7];
        wr(v, 1'b0);
        chk(reg_rdata == v, "R3", "stored value", reg_rdata, v);
        chk(flag_o == 1'b0, "R3", "flag after write", flag_o, 0);
        r0 = n_rst; i0 = n_irq;
        ticks(t - 1, 1'b1);
        chk((n_rst == r0) && (n_irq == i0), "R1", "no early pulse",
            n_rst + n_irq - r0 - i0, 0);
        ticks(1, 1'b1);
        chk(rst_req_o == st, "R6", "reset pulse", rst_req_o, st);
        chk(irq_o == !st, "R7", "irq pulse", irq_o, !st);
        cyc();
        chk(!rst_req_o && !irq_o, "R8", "pulse width", {rst_req_o, irq_o}, 0);
        chk(flag_o == 1'b1, "R5", "flag after expiry", flag_o, 1);
        chk(reg_rdata == (st ? 8'h00 : v), st ? "R6" : "R7", "value after expiry",
            reg_rdata, st ? 8'h00 : v);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int r0, i0;
        logic [7:0] v;
        void'($urandom(32'd4711));
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();

        // R9 reset state
        chk(reg_rdata == 8'h00, "R9", "value after reset", reg_rdata, 0);
        chk({flag_o, century_o, rst_req_o, irq_o} == 4'b0, "R9", "outputs after reset",
            {flag_o, century_o, rst_req_o, irq_o}, 0);

        // R11 ticks in idle are ignored
        r0 = n_rst + n_irq;
        ticks(10, 1'b0);
        chk(n_rst + n_irq == r0, "R11", "idle ticks", n_rst + n_irq - r0, 0);

        // R10 century load
        cent_ld = 1'b1; cent_val = 1'b1; cyc(); cent_ld = 1'b0;
        chk(century_o == 1'b1, "R10", "century load", century_o, 1);

        // R1 resolution variants, R7 interrupt keeps century
        run_trial(8'h09);   // mult 2, res 1 -> 8 ticks
        chk(century_o == 1'b1, "R7", "century kept", century_o, 1);
        run_trial(8'h07);   // mult 1, res 3 -> 64 ticks

        // R7 no second pulse without restart
        i0 = n_irq;
        ticks(80, 1'b0);
        chk(n_irq == i0, "R7", "single interrupt", n_irq - i0, 0);

        // R4 read re-arms; flag persists across read (R5)
        rd(1'b0);
        chk(flag_o == 1'b1, "R5", "flag after read", flag_o, 1);
        chk(reg_rdata == 8'h07, "R4", "value after read", reg_rdata, 8'h07);
        i0 = n_irq;
        ticks(63, 1'b0);
        chk(n_irq == i0, "R4", "no early pulse after read", n_irq - i0, 0);
        tick1();
        chk(irq_o == 1'b1, "R4", "pulse after re-arm", irq_o, 1);

        // R4 read mid-count restarts: 3-tick setting
        wr(8'h0C, 1'b0);
        ticks(2, 1'b0);
        rd(1'b0);
        i0 = n_irq;
        ticks(2, 1'b0);
        chk(n_irq == i0, "R4", "read restart", n_irq - i0, 0);
        tick1();
        chk(irq_o == 1'b1, "R4", "fire three ticks after read", irq_o, 1);

        // R11 tick coinciding with write is not counted (4-tick setting)
        wr(8'h05, 1'b1);
        i0 = n_irq;
        ticks(3, 1'b0);
        chk(n_irq == i0, "R11", "coincident tick ignored", n_irq - i0, 0);
        tick1();
        chk(irq_o == 1'b1, "R11", "fire after four ticks", irq_o, 1);

        // R6 reset steering clears century; R10 load wins when coincident
        run_trial(8'h84);
        chk(century_o == 1'b0, "R6", "century cleared", century_o, 0);
        cent_ld = 1'b1; cent_val = 1'b1; cyc(); cent_ld = 1'b0;
        wr(8'h84, 1'b0);
        tick1();
        chk(rst_req_o == 1'b1, "R6", "reset pulse", rst_req_o, 1);
        cent_ld = 1'b1; cent_val = 1'b1; cyc(); cent_ld = 1'b0;
        chk(century_o == 1'b1, "R10", "load beats expiry", century_o, 1);

        // R2 disabled settings
        r0 = n_rst + n_irq;
        wr(8'h00, 1'b0);
        ticks(40, 1'b0);
        wr(8'h83, 1'b0);    // multiplier 0, resolution 3
        ticks(40, 1'b0);
        rd(1'b0);
        ticks(40, 1'b0);
        chk(n_rst + n_irq == r0, "R2", "disabled quiet", n_rst + n_irq - r0, 0);
        chk(flag_o == 1'b0, "R3", "flag cleared by write", flag_o, 0);

        // Random trials
        for (int k = 0; k < 8; k++) begin
            v = 8'($urandom);
            if (v[6:2] == 5'd0) v[2] = 1'b1;
            run_trial(v);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule